// File: doc/BRIEF.md
# Registered Shift and Rotate Unit

This unit is the shift stage of a 32-bit RISC integer datapath. Each cycle it takes the six-bit function code, the five-bit instruction fields (source-register index, target-register index, destination index and shift amount), and the two source operand values. One clock edge later it returns the destination value. Supported operations are left logical, right logical, right arithmetic and right rotate shifts. Each takes its count either from the shift-amount field or from the low five bits of the source-register value.

Rotate has no function code of its own. It shares a code with the logical right shift, and a spare bit selects it. In the fixed form that bit is the lowest bit of the source-register index field. In the variable form it is the lowest bit of the shift-amount field. The encoding of a left shift with every register field zero is the canonical no-operation. The unit sorts it into three kinds: a plain idle, a superscalar issue gap, and an execution hazard barrier. It only reports the kind and takes no action on it.

Any encoding the unit does not accept raises a reserved flag and forces the result to zero.

Top module: `bshift_unit`

## Requirements
- R1: Function code 0x00 with a zero source-index field returns the target value shifted left by the shift-amount field, with zeros filling the vacated low bits.
- R2: Function code 0x02 requires bits 4:1 of the source-index field to be zero. Bit 0 of that field set to 0 gives a logical right shift by the shift-amount field, and set to 1 gives a right rotate by the same amount.
- R3: Function code 0x06 takes bit 0 of the shift-amount field as its selector. A value of 0 gives a logical right shift by the source value, and 1 gives a right rotate. Bits 4:1 of that field are ignored.
- R4: The register-count forms are codes 0x04 (left logical), 0x06 and 0x07 (right arithmetic). They use only bits 4:0 of the source value as the count, and higher source bits have no effect on the result.
- R5: Arithmetic right shifts (codes 0x03 and 0x07) fill the vacated high bits with copies of target bit 31. Code 0x03 requires a zero source-index field.
- R6: A right rotate by n returns (t << (32-n)) | (t >> n) taken modulo 32 bits. A rotate or shift by 0 returns the target value unchanged.
- R7: Code 0x00 with the source, target and destination index fields all zero flags the encoding. A shift amount of 1 raises the issue-gap flag, 3 raises the hazard-barrier flag, and any other amount raises the idle flag. The result is still the left shift.
- R8: A function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07, or a fixed form whose reserved index bits are non-zero, raises the reserved flag, clears the other three flags and gives a result of zero.
- R9: Outputs are registered. The values for the inputs present at a rising edge appear after that edge. A synchronous active-high reset clears the result and all flags.
- R10: At most one of the four flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| funct_i | input | 6 | Function code |
| rs_fld_i | input | 5 | Source-register index field |
| rt_fld_i | input | 5 | Target-register index field |
| rd_fld_i | input | 5 | Destination index field |
| sa_fld_i | input | 5 | Shift-amount field |
| rs_val_i | input | DATA_W | Source register value (count for variable forms) |
| rt_val_i | input | DATA_W | Target register value (data to shift) |
| rd_val_o | output | DATA_W | Registered result |
| idle_o | output | 1 | Plain no-operation encoding seen |
| issue_gap_o | output | 1 | Superscalar issue-gap encoding seen |
| hazard_bar_o | output | 1 | Execution hazard barrier encoding seen |
| resv_o | output | 1 | Reserved encoding seen |

## Verification
Each of the eight shift variants is swept over all 32 counts. The operands used are all-ones, a lone sign bit, a lone low bit, alternating bits and random words. All-ones and the lone bits show where bits leave the word and whether the fill is zeros, sign copies or wrapped bits. Alternating and random words catch swapped or off-by-one stages. Variable forms get random upper bits in the count register and random ignored selector bits, so a count that leaks past bit 4 shows up. Dedicated cases cover the three no-op kinds, a near-no-op with a non-zero destination, the unknown function codes and the illegal reserved fields.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;

  typedef enum logic [1:0] {
    K_LEFT  = 2'd0,
    K_RLOG  = 2'd1,
    K_RARI  = 2'd2,
    K_ROT   = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    NK_NONE = 2'd0,
    NK_IDLE = 2'd1,
    NK_GAP  = 2'd2,
    NK_BAR  = 2'd3
  } nop_kind_e;

  typedef struct packed {
    shift_kind_e kind;
    logic        use_reg;
    logic        resv;
    nop_kind_e   nopk;
  } shift_dec_t;

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int FLD_W = 5
) (
  input  logic [5:0]       funct,
  input  logic [FLD_W-1:0] rs_f,
  input  logic [FLD_W-1:0] rt_f,
  input  logic [FLD_W-1:0] rd_f,
  input  logic [FLD_W-1:0] sa_f,
  output shift_dec_t       dec
);

  logic all_idx_zero;
  assign all_idx_zero = (rs_f == '0) && (rt_f == '0) && (rd_f == '0);

  always_comb begin
    dec.kind    = K_LEFT;
    dec.use_reg = 1'b0;
    dec.resv    = 1'b1;
    dec.nopk    = NK_NONE;
    unique case (funct)
      FN_SLL: begin
        dec.resv = (rs_f != '0);
        if (all_idx_zero) begin
          if (sa_f == FLD_W'(1))      dec.nopk = NK_GAP;
          else if (sa_f == FLD_W'(3)) dec.nopk = NK_BAR;
          else                        dec.nopk = NK_IDLE;
        end
      end
      FN_SRL: begin
        dec.kind = rs_f[0] ? K_ROT : K_RLOG;
        dec.resv = (rs_f[FLD_W-1:1] != '0);
      end
      FN_SRA: begin
        dec.kind = K_RARI;
        dec.resv = (rs_f != '0);
      end
      FN_SLLV: begin
        dec.use_reg = 1'b1;
        dec.resv    = 1'b0;
      end
      FN_SRLV: begin
        dec.kind    = sa_f[0] ? K_ROT : K_RLOG;
        dec.use_reg = 1'b1;
        dec.resv    = 1'b0;
      end
      FN_SRAV: begin
        dec.kind    = K_RARI;
        dec.use_reg = 1'b1;
        dec.resv    = 1'b0;
      end
      default: begin
        dec.resv = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SH_W-1:0]   amt,
  input  shift_kind_e       kind,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stg [0:SH_W];
  logic              fill;
  logic              is_rot;

  // Left shifts run through the right-shift network on a mirrored word.
  assign stg[0] = (kind == K_LEFT) ? bit_rev(data) : data;
  assign fill   = (kind == K_RARI) & data[DATA_W-1];
  assign is_rot = (kind == K_ROT);

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int S = 1 << g;
    logic [S-1:0] hi_bits;
    assign hi_bits = is_rot ? stg[g][S-1:0] : {S{fill}};
    assign stg[g+1] = amt[g] ? {hi_bits, stg[g][DATA_W-1:S]} : stg[g];
  end

  assign result = (kind == K_LEFT) ? bit_rev(stg[SH_W]) : stg[SH_W];

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        funct_i,
  input  logic [4:0]        rs_fld_i,
  input  logic [4:0]        rt_fld_i,
  input  logic [4:0]        rd_fld_i,
  input  logic [4:0]        sa_fld_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic              idle_o,
  output logic              issue_gap_o,
  output logic              hazard_bar_o,
  output logic              resv_o
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int FLD_W = 5;

  shift_dec_t        dec;
  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] shifted;

  bshift_decode #(.FLD_W(FLD_W)) u_dec (
    .funct (funct_i),
    .rs_f  (rs_fld_i),
    .rt_f  (rt_fld_i),
    .rd_f  (rd_fld_i),
    .sa_f  (sa_fld_i),
    .dec   (dec)
  );

  assign amt = dec.use_reg ? rs_val_i[SH_W-1:0] : sa_fld_i[SH_W-1:0];

  bshift_core #(.DATA_W(DATA_W)) u_core (
    .data   (rt_val_i),
    .amt    (amt),
    .kind   (dec.kind),
    .result (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val_o     <= '0;
      idle_o       <= 1'b0;
      issue_gap_o  <= 1'b0;
      hazard_bar_o <= 1'b0;
      resv_o       <= 1'b0;
    end else begin
      rd_val_o     <= dec.resv ? '0 : shifted;
      resv_o       <= dec.resv;
      idle_o       <= !dec.resv && (dec.nopk == NK_IDLE);
      issue_gap_o  <= !dec.resv && (dec.nopk == NK_GAP);
      hazard_bar_o <= !dec.resv && (dec.nopk == NK_BAR);
    end
  end

endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [5:0]        funct_i,
  input logic [4:0]        rs_fld_i,
  input logic [4:0]        sa_fld_i,
  input logic [DATA_W-1:0] rt_val_i,
  input logic [DATA_W-1:0] rd_val_o,
  input logic              idle_o,
  input logic              issue_gap_o,
  input logic              hazard_bar_o,
  input logic              resv_o
);

  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({idle_o, issue_gap_o, hazard_bar_o, resv_o}));

  // R8
  resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    resv_o |-> (rd_val_o == '0));

  // R8
  unknown_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(funct_i) inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07}))
    |-> resv_o);

  // R6
  rot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(funct_i) == 6'h02 && $past(rs_fld_i) == 5'd1 && $past(sa_fld_i) == 5'd0)
    |-> (rd_val_o == $past(rt_val_i)));

  // R5
  sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(funct_i) == 6'h03 && $past(rs_fld_i) == 5'd0 && $past(rt_val_i[DATA_W-1]))
    |-> rd_val_o[DATA_W-1]);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_val_o == '0 && !idle_o && !issue_gap_o && !hazard_bar_o && !resv_o));

endmodule

bind bshift_unit bshift_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .funct_i      (funct_i),
  .rs_fld_i     (rs_fld_i),
  .sa_fld_i     (sa_fld_i),
  .rt_val_i     (rt_val_i),
  .rd_val_o     (rd_val_o),
  .idle_o       (idle_o),
  .issue_gap_o  (issue_gap_o),
  .hazard_bar_o (hazard_bar_o),
  .resv_o       (resv_o)
);

// File: tb/bshift_unit_tb_top.sv
`timescale 1ns/1ps
module bshift_unit_tb_top;

  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [5:0]        funct_i = '0;
  logic [4:0]        rs_fld_i = '0, rt_fld_i = '0, rd_fld_i = '0, sa_fld_i = '0;
  logic [DATA_W-1:0] rs_val_i = '0, rt_val_i = '0;
  logic [DATA_W-1:0] rd_val_o;
  logic              idle_o, issue_gap_o, hazard_bar_o, resv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bshift_unit #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .funct_i(funct_i), .rs_fld_i(rs_fld_i),
    .rt_fld_i(rt_fld_i), .rd_fld_i(rd_fld_i), .sa_fld_i(sa_fld_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .rd_val_o(rd_val_o),
    .idle_o(idle_o), .issue_gap_o(issue_gap_o), .hazard_bar_o(hazard_bar_o),
    .resv_o(resv_o)
  );

  // flags packed as {idle, gap, barrier, reserved}
  task automatic compare(input string tag, input logic [DATA_W-1:0] exp_v, input logic [3:0] exp_f);
    logic [3:0] act_f;
    act_f = {idle_o, issue_gap_o, hazard_bar_o, resv_o};
    n_checks++;
    if (rd_val_o !== exp_v || act_f !== exp_f) begin
      n_fail++;
      $display("FAIL %s: result %h flags %b, expected result %h flags %b",
               tag, rd_val_o, act_f, exp_v, exp_f);
    end
  endtask

  // Inputs are set at a falling edge; the registered output is read one falling edge later.
  task automatic run(input string tag, input logic [5:0] fn, input logic [4:0] rs_f,
                     input logic [4:0] rt_f, input logic [4:0] rd_f, input logic [4:0] sa_f,
                     input logic [DATA_W-1:0] rs_v, input logic [DATA_W-1:0] rt_v,
                     input logic [DATA_W-1:0] exp_v, input logic [3:0] exp_f);
    funct_i = fn; rs_fld_i = rs_f; rt_fld_i = rt_f; rd_fld_i = rd_f;
    sa_fld_i = sa_f; rs_val_i = rs_v; rt_val_i = rt_v;
    @(negedge clk);
    compare(tag, exp_v, exp_f);
  endtask

  function automatic logic [DATA_W-1:0] ref_rot(input logic [DATA_W-1:0] t, input int n);
    logic [2*DATA_W-1:0] dbl;
    dbl = {t, t} >> n;
    return dbl[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] ref_sra(input logic [DATA_W-1:0] t, input int n);
    logic [DATA_W-1:0] r;
    r = t >> n;
    for (int i = 0; i < n; i++) r[DATA_W-1-i] = t[DATA_W-1];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pattern(input int p);
    case (p)
      0: return '1;
      1: return 32'h8000_0000;
      2: return 32'h0000_0001;
      3: return 32'hA5A5_5A5A;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset clears outputs even with live inputs
    funct_i = 6'h00; rt_val_i = 32'hFFFF_FFFF; sa_fld_i = 5'd4; rt_fld_i = 5'd3;
    @(negedge clk); @(negedge clk);
    compare("R9 reset", '0, 4'b0000);
    rst = 1'b0;

    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 32; n++) begin
        logic [DATA_W-1:0] t;
        logic [DATA_W-1:0] up;
        logic [4:0] junk;
        t    = pattern(p);
        up   = $urandom() & ~32'h1F;
        junk = 5'($urandom());
        // R1: fixed left
        run("R1 sll", 6'h00, 5'd0, 5'd7, 5'd9, 5'(n), 0, t, t << n, 4'b0000);
        // R2: fixed logical right
        run("R2 srl", 6'h02, 5'd0, 5'd7, 5'd9, 5'(n), 0, t, t >> n, 4'b0000);
        // R6: fixed rotate
        run("R6 rotr", 6'h02, 5'd1, 5'd7, 5'd9, 5'(n), 0, t, ref_rot(t, n), 4'b0000);
        // R5: fixed arithmetic
        run("R5 sra", 6'h03, 5'd0, 5'd7, 5'd9, 5'(n), 0, t, ref_sra(t, n), 4'b0000);
        // R4: variable left, upper count bits and shift field ignored
        run("R4 sllv", 6'h04, 5'd2, 5'd7, 5'd9, junk, up | n, t, t << n, 4'b0000);
        // R3: variable logical right, selector bit 0 of shift field
        run("R3 srlv", 6'h06, 5'd2, 5'd7, 5'd9, {junk[4:1], 1'b0}, up | n, t, t >> n, 4'b0000);
        run("R3 rotrv", 6'h06, 5'd2, 5'd7, 5'd9, {junk[4:1], 1'b1}, up | n, t, ref_rot(t, n), 4'b0000);
        // R4 with R5 fill
        run("R4 srav", 6'h07, 5'd2, 5'd7, 5'd9, junk, up | n, t, ref_sra(t, n), 4'b0000);
      end
    end

    // R6: zero rotate keeps operand
    run("R6 rot0", 6'h06, 5'd0, 5'd1, 5'd1, 5'd1, 32'hFFFF_FFE0, 32'h1234_5678, 32'h1234_5678, 4'b0000);

    // R7: no-op kinds
    run("R7 idle", 6'h00, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 0, 4'b1000);
    run("R7 gap",  6'h00, 5'd0, 5'd0, 5'd0, 5'd1, 0, 0, 0, 4'b0100);
    run("R7 barrier", 6'h00, 5'd0, 5'd0, 5'd0, 5'd3, 0, 0, 0, 4'b0010);
    run("R7 other", 6'h00, 5'd0, 5'd0, 5'd0, 5'd2, 0, 0, 0, 4'b1000);
    run("R7 nonzero rd", 6'h00, 5'd0, 5'd0, 5'd4, 5'd1, 0, 0, 0, 4'b0000);
    run("R7 nonzero rt", 6'h00, 5'd0, 5'd2, 5'd0, 5'd3, 0, 32'h3, 32'h18, 4'b0000);

    // R8: unknown codes and illegal reserved fields
    for (int f = 0; f < 64; f++) begin
      if (!(f inside {0, 2, 3, 4, 6, 7}))
        run("R8 code", 6'(f), 5'd0, 5'd1, 5'd1, 5'd2, 32'h3, 32'hFFFF_FFFF, '0, 4'b0001);
    end
    run("R8 sll rs", 6'h00, 5'd1, 5'd0, 5'd0, 5'd1, 0, 32'hF, '0, 4'b0001);
    run("R8 srl rs", 6'h02, 5'd2, 5'd1, 5'd1, 5'd1, 0, 32'hF, '0, 4'b0001);
    run("R8 sra rs", 6'h03, 5'd16, 5'd1, 5'd1, 5'd1, 0, 32'hF, '0, 4'b0001);

    // R9: reset in mid-run clears outputs
    funct_i = 6'h00; rs_fld_i = 0; sa_fld_i = 5'd1; rt_val_i = 32'h1; rt_fld_i = 5'd2;
    rst = 1'b1;
    @(negedge clk);
    compare("R9 mid reset", '0, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    compare("R9 after reset", 32'h2, 4'b0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule